// File: doc/BRIEF.md
# Dual-Select Timer Clock Prescaler

This block is the shared time base for two timer counters, a capture/compare counter and a PWM counter. A 9-bit free-running divider advances once per system clock. Each counter has its own 3-bit selector. A selector picks one of seven power-of-two divider taps or the synchronized external clock pin. The result drives a registered tick output that is high for one system clock. The counters use these ticks as count enables, so everything stays in one clock domain.

Software reaches the block over a simple register bus. The bus has a read strobe, a write strobe, byte enables and a 16-bit data path. The capture/compare selector is meant to be set once by initialization code, after which it is locked. The PWM selector can be changed at any time. The raw divider value can always be read. It can be loaded only while the chip is in freeze (debug halt). In freeze the divider stops, so a loaded value holds until freeze is released.

Top module: `dual_tick_prescaler`

## Requirements
- R1: After reset, the capture/compare select field reads 1 (divide by 4) and the PWM select field reads 0 (divide by 2). Both tick outputs are low while reset is asserted.
- R2: Select code s in 0..6 taps divider bit s. Whenever a clock edge advances the divider to a value whose low s+1 bits equal 2^s, the tick is high for the one clock that follows that edge. The tick therefore repeats every 2^(s+1) cycles.
- R3: Select code 7 uses the external pin through a two-flop synchronizer. Each rising edge of the pin gives exactly one tick, one clock wide. A pin that rises before clock edge A gives a tick visible after edge A+2.
- R4: A write to address 1 with byte enable 0 set loads the PWM select field from data bits [2:0]. This works at any time.
- R5: A write to address 0 with byte enable 0 set loads the capture/compare select field from data bits [2:0]. Only the first such write after reset takes effect. Later writes are ignored unless the test or freeze input is high.
- R6: A read returns data combinationally while the read strobe is high. Address 0 gives the capture/compare select in bits [2:0]. Address 1 gives the PWM select in bits [2:0]. Address 2 gives the divider value in bits [8:0]. Address 3 reads zero, and all other bits read zero.
- R7: A write to address 2 loads the divider only while freeze is high. Otherwise the divider keeps counting and the write is lost.
- R8: In a divider load, byte enable 0 writes divider bits [7:0] from data [7:0]. Byte enable 1 writes divider bit 8 from data bit 8. Bits whose lane is not enabled keep their value.
- R9: While freeze is high, the divider holds its value and divider-tap ticks stay low. After freeze is released, counting resumes from the held or loaded value.
- R10: The divider wraps from 511 to 0, and tap ticks follow across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze_i | input | 1 | Debug freeze: stops the divider and opens the write locks |
| test_i | input | 1 | Test mode: opens the capture/compare select lock |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| bus_addr_i | input | 2 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_be_i | input | 2 | Byte enables, bit n covers data bits [8n+7:8n] |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, zero when no read |
| cap_tick_o | output | 1 | Count-enable tick for the capture/compare counter |
| pwm_tick_o | output | 1 | Count-enable tick for the PWM counter |

## Verification
The bench loads a known divider value in freeze, releases it, and counts ticks over a fixed window. This exposes a tap off by one bit, a tick emitted on the falling transition, and a wrong count across the 511-to-0 wrap. It checks the write-once lock before and after the test and freeze overrides; a design that ignored the overrides, or never locked, would read back the wrong select code. The bench also writes the divider while it is running and then reads it back: a design that did not gate the load on freeze would show the written value instead of the next count. It also does byte-lane loads, where a design that ignored byte enables would corrupt the other lane. The external pin is timed to the exact cycle, which catches a missing or extra synchronizer stage and a tick that lasts more than one cycle.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CAP_SEL  = 2'd0,
      REG_PWM_SEL  = 2'd1,
      REG_PRESCALE = 2'd2,
      REG_SPARE    = 2'd3
   } tpre_reg_e;

   function automatic int unsigned lane_of(input int unsigned bit_idx);
      return bit_idx / 8;
   endfunction

endpackage

// File: rtl/tpre_divider.sv
module tpre_divider #(
   parameter int unsigned DIV_W = 9,
   parameter int unsigned NTAPS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic             load_i,
   input  logic [DIV_W-1:0] load_val_i,
   output logic [DIV_W-1:0] cnt_o,
   output logic [NTAPS-1:0] tap_rise_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             advance;

   if (NTAPS > DIV_W) begin : g_bad_taps
      $error("tpre_divider: NTAPS exceeds divider width");
   end

   assign advance = !freeze_i && !load_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (!freeze_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // bit k rises on the next increment when it is 0 and all lower bits are 1
   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam logic [DIV_W-1:0] LOW_MASK = DIV_W'((64'd1 << k) - 64'd1);
      assign tap_rise_o[k] = advance && !cnt_q[k] && ((cnt_q & LOW_MASK) == LOW_MASK);
   end

   assign cnt_o = cnt_q;

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_i && !load_i) |=> $stable(cnt_q)); // R9

   AST_DIV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze_i && !load_i && (&cnt_q)) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/tpre_pin_sync.sv
module tpre_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);

   logic [STAGES-1:0] st_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("tpre_pin_sync: at least two synchronizer stages required");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         st_q   <= {st_q[STAGES-2:0], pin_i};
         prev_q <= st_q[STAGES-1];
      end
   end

   assign rise_o = st_q[STAGES-1] && !prev_q;

   AST_PIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R3

endmodule

// File: rtl/tpre_tick_sel.sv
module tpre_tick_sel #(
   parameter int unsigned SEL_W = 3,
   parameter int unsigned NTAPS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [NTAPS-1:0] tap_rise_i,
   input  logic             pin_rise_i,
   output logic             tick_o
);

   localparam int unsigned NSRC = 2 ** SEL_W;
   localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'(NSRC - 1);

   logic [NSRC-1:0] src;
   logic            tick_q;

   if (NTAPS != NSRC - 1) begin : g_bad_sel
      $error("tpre_tick_sel: NTAPS must be 2**SEL_W - 1");
   end

   assign src = {pin_rise_i, tap_rise_i};

   always_ff @(posedge clk) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= src[sel_i];
   end

   assign tick_o = tick_q;

   AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_i && sel_i != EXT_CODE) |=> !tick_o); // R9

endmodule

// File: rtl/tpre_regs.sv
module tpre_regs
   import tpre_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DIV_W   = 9,
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned CAP_RST = 1,
   parameter int unsigned PWM_RST = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  freeze_i,
   input  logic                  test_i,
   input  logic [REG_ADDR_W-1:0] bus_addr_i,
   input  logic                  bus_rd_i,
   input  logic                  bus_wr_i,
   input  logic [DATA_W/8-1:0]   bus_be_i,
   input  logic [DATA_W-1:0]     bus_wdata_i,
   output logic [DATA_W-1:0]     bus_rdata_o,
   input  logic [DIV_W-1:0]      cnt_i,
   output logic [SEL_W-1:0]      cap_sel_o,
   output logic [SEL_W-1:0]      pwm_sel_o,
   output logic                  load_o,
   output logic [DIV_W-1:0]      load_val_o
);

   localparam int unsigned LANES = DATA_W / 8;

   if (DIV_W > DATA_W || SEL_W > 8 || DATA_W % 8 != 0) begin : g_bad_widths
      $error("tpre_regs: field widths do not fit the data path");
   end

   tpre_reg_e        reg_sel;
   logic             wr_cap, wr_pwm, cap_open;
   logic             cap_lock_q;
   logic [SEL_W-1:0] cap_sel_q, pwm_sel_q;
   logic             unused_wdata;

   assign reg_sel  = tpre_reg_e'(bus_addr_i);
   assign wr_cap   = bus_wr_i && (reg_sel == REG_CAP_SEL) && bus_be_i[0];
   assign wr_pwm   = bus_wr_i && (reg_sel == REG_PWM_SEL) && bus_be_i[0];
   assign cap_open = !cap_lock_q || test_i || freeze_i;
   assign load_o   = bus_wr_i && (reg_sel == REG_PRESCALE) && freeze_i && (|bus_be_i);
   assign unused_wdata = ^bus_wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_sel_q  <= SEL_W'(CAP_RST);
         pwm_sel_q  <= SEL_W'(PWM_RST);
         cap_lock_q <= 1'b0;
      end else begin
         if (wr_cap && cap_open) begin
            cap_sel_q  <= bus_wdata_i[SEL_W-1:0];
            cap_lock_q <= 1'b1;
         end
         if (wr_pwm) begin
            pwm_sel_q <= bus_wdata_i[SEL_W-1:0];
         end
      end
   end

   for (genvar b = 0; b < DIV_W; b++) begin : g_lane
      localparam int unsigned LANE = lane_of(b);
      if (LANE < LANES) begin : g_in
         assign load_val_o[b] = bus_be_i[LANE] ? bus_wdata_i[b] : cnt_i[b];
      end else begin : g_out
         assign load_val_o[b] = cnt_i[b];
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_rd_i) begin
         unique case (reg_sel)
            REG_CAP_SEL:  bus_rdata_o[SEL_W-1:0] = cap_sel_q;
            REG_PWM_SEL:  bus_rdata_o[SEL_W-1:0] = pwm_sel_q;
            REG_PRESCALE: bus_rdata_o[DIV_W-1:0] = cnt_i;
            default:      bus_rdata_o = '0;
         endcase
      end
   end

   assign cap_sel_o = cap_sel_q;
   assign pwm_sel_o = pwm_sel_q;

   AST_CAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_lock_q && !test_i && !freeze_i) |=> $stable(cap_sel_q)); // R5

   AST_PWM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pwm |=> (pwm_sel_q == $past(bus_wdata_i[SEL_W-1:0]))); // R4

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rdata_o >> DIV_W) == '0)); // R6

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |-> (bus_rdata_o == '0)); // R6

endmodule

// File: rtl/dual_tick_prescaler.sv
module dual_tick_prescaler
   import tpre_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned DIV_W       = 9,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CAP_RST_SEL = 1,
   parameter int unsigned PWM_RST_SEL = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  freeze_i,
   input  logic                  test_i,
   input  logic                  ext_clk_i,
   input  logic [REG_ADDR_W-1:0] bus_addr_i,
   input  logic                  bus_rd_i,
   input  logic                  bus_wr_i,
   input  logic [DATA_W/8-1:0]   bus_be_i,
   input  logic [DATA_W-1:0]     bus_wdata_i,
   output logic [DATA_W-1:0]     bus_rdata_o,
   output logic                  cap_tick_o,
   output logic                  pwm_tick_o
);

   localparam int unsigned NTAPS = (2 ** SEL_W) - 1;
   localparam int unsigned NCHAN = 2;

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] load_val;
   logic             load;
   logic [NTAPS-1:0] tap_rise;
   logic             pin_rise;
   logic [SEL_W-1:0] chan_sel  [NCHAN];
   logic [NCHAN-1:0] chan_tick;

   tpre_regs #(
      .DATA_W  (DATA_W),
      .DIV_W   (DIV_W),
      .SEL_W   (SEL_W),
      .CAP_RST (CAP_RST_SEL),
      .PWM_RST (PWM_RST_SEL)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .freeze_i    (freeze_i),
      .test_i      (test_i),
      .bus_addr_i  (bus_addr_i),
      .bus_rd_i    (bus_rd_i),
      .bus_wr_i    (bus_wr_i),
      .bus_be_i    (bus_be_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .cnt_i       (cnt),
      .cap_sel_o   (chan_sel[0]),
      .pwm_sel_o   (chan_sel[1]),
      .load_o      (load),
      .load_val_o  (load_val)
   );

   tpre_divider #(
      .DIV_W (DIV_W),
      .NTAPS (NTAPS)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze_i   (freeze_i),
      .load_i     (load),
      .load_val_i (load_val),
      .cnt_o      (cnt),
      .tap_rise_o (tap_rise)
   );

   tpre_pin_sync #(
      .STAGES (SYNC_STAGES)
   ) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_clk_i),
      .rise_o (pin_rise)
   );

   for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      tpre_tick_sel #(
         .SEL_W (SEL_W),
         .NTAPS (NTAPS)
      ) u_sel (
         .clk        (clk),
         .rst_n      (rst_n),
         .freeze_i   (freeze_i),
         .sel_i      (chan_sel[c]),
         .tap_rise_i (tap_rise),
         .pin_rise_i (pin_rise),
         .tick_o     (chan_tick[c])
      );
   end

   assign cap_tick_o = chan_tick[0];
   assign pwm_tick_o = chan_tick[1];

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!cap_tick_o && !pwm_tick_o)); // R1

endmodule

// File: tb/dual_tick_prescaler_bench.sv
module dual_tick_prescaler_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b0;
   logic        test = 1'b0;
   logic        pin = 1'b0;
   logic [1:0]  addr = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  be = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        cap_tick, pwm_tick;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dual_tick_prescaler u_dual_tick_prescaler (
      .clk         (clk),
      .rst_n       (rst_n),
      .freeze_i    (freeze),
      .test_i      (test),
      .ext_clk_i   (pin),
      .bus_addr_i  (addr),
      .bus_rd_i    (rd),
      .bus_wr_i    (wr),
      .bus_be_i    (be),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cap_tick_o  (cap_tick),
      .pwm_tick_o  (pwm_tick)
   );

   // {chan(1: cap, 0: pwm), sel[2:0], load[8:0], cycles[7:0], ticks[3:0]}
   localparam logic [24:0] VECS [0:9] = '{
      {1'b0, 3'd0, 9'd0,   8'd16, 4'd8},
      {1'b0, 3'd2, 9'd0,   8'd32, 4'd4},
      {1'b0, 3'd2, 9'd3,   8'd8,  4'd1},
      {1'b1, 3'd2, 9'd5,   8'd8,  4'd1},
      {1'b1, 3'd6, 9'd0,   8'd64, 4'd1},
      {1'b0, 3'd6, 9'd0,   8'd63, 4'd0},
      {1'b0, 3'd0, 9'd511, 8'd2,  4'd1},
      {1'b1, 3'd3, 9'd500, 8'd20, 4'd2},
      {1'b0, 3'd5, 9'd31,  8'd1,  4'd1},
      {1'b1, 3'd1, 9'd1,   8'd4,  4'd1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic [1:0] b);
      addr = a; wdata = d; be = b; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; be = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
      addr = a; rd = 1'b1;
      #1;
      d = rdata;
      rd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] r;
      logic [15:0] r0;
      int ticks;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 cap tick in reset", {31'd0, cap_tick}, 32'd0);
      chk("R1 pwm tick in reset", {31'd0, pwm_tick}, 32'd0);
      rst_n = 1'b1;
      bus_read(2'd0, r);
      chk("R1 cap select default", {16'd0, r}, 32'd1);
      bus_read(2'd1, r);
      chk("R1 pwm select default", {16'd0, r}, 32'd0);
      bus_read(2'd3, r);
      chk("R6 spare address", {16'd0, r}, 32'd0);

      // R2 R10: vector table, load in freeze then count ticks
      for (int i = 0; i < 10; i++) begin
         freeze = 1'b1;
         bus_write(2'd2, {7'd0, VECS[i][20:12]}, 2'b11);
         bus_write(VECS[i][24] ? 2'd0 : 2'd1, {13'd0, VECS[i][23:21]}, 2'b01);
         freeze = 1'b0;
         ticks = 0;
         for (int k = 0; k < int'(VECS[i][11:4]); k++) begin
            @(posedge clk);
            @(negedge clk);
            if (VECS[i][24] ? cap_tick : pwm_tick) ticks++;
         end
         chk($sformatf("R2 R10 vector %0d", i), ticks, {28'd0, VECS[i][3:0]});
      end

      // R5: write-once capture select
      do_reset();
      bus_write(2'd0, 16'h0000, 2'b01);
      bus_read(2'd0, r);
      chk("R5 first write taken", {16'd0, r}, 32'd0);
      bus_write(2'd0, 16'h0005, 2'b01);
      bus_read(2'd0, r);
      chk("R5 second write ignored", {16'd0, r}, 32'd0);
      test = 1'b1;
      bus_write(2'd0, 16'h0005, 2'b01);
      test = 1'b0;
      bus_read(2'd0, r);
      chk("R5 test mode write", {16'd0, r}, 32'd5);
      bus_write(2'd0, 16'h0002, 2'b01);
      bus_read(2'd0, r);
      chk("R5 locked again", {16'd0, r}, 32'd5);

      // R4: PWM select always writable
      bus_write(2'd1, 16'h0003, 2'b01);
      bus_read(2'd1, r);
      chk("R4 pwm write 3", {16'd0, r}, 32'd3);
      bus_write(2'd1, 16'hFFF6, 2'b11);
      bus_read(2'd1, r);
      chk("R4 R6 pwm write 6", {16'd0, r}, 32'd6);

      // R7: divider write outside freeze is lost
      bus_read(2'd2, r0);
      bus_write(2'd2, 16'h0155, 2'b11);
      bus_read(2'd2, r);
      chk("R7 running write ignored", {16'd0, r}, {23'd0, 9'(r0[8:0] + 9'd1)});

      // R8: byte lanes
      freeze = 1'b1;
      bus_write(2'd2, 16'h01FF, 2'b11);
      bus_write(2'd2, 16'hFE22, 2'b01);
      bus_read(2'd2, r);
      chk("R8 low lane", {16'd0, r}, 32'h122);
      bus_write(2'd2, 16'h0000, 2'b10);
      bus_read(2'd2, r);
      chk("R8 R6 high lane", {16'd0, r}, 32'h022);

      // R9: freeze holds value, no tap ticks
      bus_write(2'd1, 16'h0000, 2'b01);
      ticks = 0;
      for (int k = 0; k < 10; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (pwm_tick) ticks++;
      end
      chk("R9 no ticks in freeze", ticks, 0);
      bus_read(2'd2, r);
      chk("R9 value held", {16'd0, r}, 32'h022);
      freeze = 1'b0;
      @(posedge clk);
      @(negedge clk);
      bus_read(2'd2, r);
      chk("R9 resumes from held", {16'd0, r}, 32'h023);

      // R3: external pin latency and single tick
      bus_write(2'd1, 16'h0007, 2'b01);
      repeat (4) @(negedge clk);
      pin = 1'b1;
      @(negedge clk);
      chk("R3 after edge A", {31'd0, pwm_tick}, 32'd0);
      @(negedge clk);
      chk("R3 after edge A+1", {31'd0, pwm_tick}, 32'd0);
      @(negedge clk);
      chk("R3 after edge A+2", {31'd0, pwm_tick}, 32'd1);
      @(negedge clk);
      chk("R3 one cycle wide", {31'd0, pwm_tick}, 32'd0);
      ticks = 0;
      for (int p = 0; p < 2; p++) begin
         repeat (5) @(negedge clk);
         pin = 1'b0;
         repeat (5) @(negedge clk);
         pin = 1'b1;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (pwm_tick) ticks++;
         end
      end
      chk("R3 one tick per edge", ticks, 2);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule